// File: doc/BRIEF.md
# Command Mailbox Register Interface

This block is a four-word register window through which a host processor hands numbered commands to a local controller and reads back the outcome. The host uses a plain word-wide register port. A write of a command number into the status/command word starts an operation and raises a busy flag. The two data words carry the operation's arguments to the controller and later return its results. When the operation fails, the first data word returns an error code instead.

The controller side sees the command number, both argument words and a one-cycle start strobe. It answers with a single-cycle done pulse together with an error flag and two result words. Completion can optionally raise an interrupt. The interrupt stays pending until the host writes the version word. Reading the version word returns a fixed hardware version constant.

The window sits at a parameterised base address, 0x1FFF_0000 by default. Byte offsets inside the window are: status/command +0x0, first data word +0x4, second data word +0x8, version +0xC.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, the status word, both data words and `irq` read 0, and `ctl_start` is low.
- R2: The status word has this layout: bit 31 is busy, bit 30 is error, bit 29 is interrupt pending, bits 7:0 hold the last accepted command number, and bits 28:8 read 0.
- R3: A status write while idle is accepted on that clock edge. After the edge, busy reads 1, `ctl_cmd` equals `host_wdata[7:0]`, and `ctl_start` is high for exactly one cycle.
- R4: A status write while busy is ignored. No start strobe is issued, and the command number and flags do not change.
- R5: While idle, writes to offsets +0x4 and +0x8 store the word. The stored word reads back and drives `ctl_arg0` / `ctl_arg1`.
- R6: While busy, writes to both data words are ignored, so the arguments stay stable.
- R7: A done pulse while busy has three effects on the same edge: busy clears, the error flag takes `ctl_error`, and the data words take `ctl_res0` / `ctl_res1`. When the error flag is set, the first data word therefore holds the error code.
- R8: Accepting a new command clears the error flag.
- R9: A done pulse while idle has no effect on the flags or the data words.
- R10: Completion sets interrupt pending, and `irq` follows it. A write to offset +0xC clears it. When a completion and a +0xC write land on the same edge, the set wins.
- R11: Offset +0xC reads the `HW_VERSION` parameter (default 0x4D42_0001), and writes do not change it.
- R12: Addresses outside the four-word window read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write enable for this cycle |
| host_addr | input | 32 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational from address) |
| ctl_start | output | 1 | One-cycle strobe: a new command was accepted |
| ctl_cmd | output | 8 | Current command number |
| ctl_arg0 | output | 32 | First argument word |
| ctl_arg1 | output | 32 | Second argument word |
| ctl_done | input | 1 | Controller completion pulse |
| ctl_error | input | 1 | Failure flag, qualified by `ctl_done` |
| ctl_res0 | input | 32 | First result word or error code |
| ctl_res1 | input | 32 | Second result word |
| irq | output | 1 | Completion interrupt (pending flag) |

## Verification
The hardest situation to reach is a completion pulse and an interrupt-clear write arriving on the same clock edge. Nearby is a command write that arrives while an earlier one is still busy. The stimulus builds a busy state first and holds it by never answering from the controller. During that state it issues the rejected command and data writes. It then drives `ctl_done` and the version-word write inside one cycle, and checks that the interrupt survives. A stray done pulse after completion checks that an idle mailbox leaves the latched results alone.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   typedef enum logic [1:0] {
      SEL_STAT = 2'd0,
      SEL_WD0  = 2'd1,
      SEL_WD1  = 2'd2,
      SEL_VER  = 2'd3
   } mbx_sel_t;

   localparam int unsigned BUSY_POS = 31;
   localparam int unsigned FAIL_POS = 30;
   localparam int unsigned PEND_POS = 29;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
   parameter int unsigned    ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h1FFF_0000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output logic              hit,
   output mbx_pkg::mbx_sel_t sel,
   output logic              wr_stat,
   output logic              wr_wd0,
   output logic              wr_wd1,
   output logic              wr_ver
);
   import mbx_pkg::*;

   localparam int unsigned OFS_W = 4;

   generate
      if (BASE_ADDR[OFS_W-1:0] != '0) begin : g_bad_base
         $error("mbx_decode: BASE_ADDR must be 16-byte aligned");
      end
   endgenerate

   always_comb begin
      hit     = (addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
      sel     = mbx_sel_t'(addr[3:2]);
      wr_stat = wr && hit && (sel == SEL_STAT);
      wr_wd0  = wr && hit && (sel == SEL_WD0);
      wr_wd1  = wr && hit && (sel == SEL_WD1);
      wr_ver  = wr && hit && (sel == SEL_VER);
   end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl #(
   parameter int unsigned CMD_W  = 8,
   parameter bit          IRQ_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic             ver_wr,
   input  logic [CMD_W-1:0] cmd_in,
   input  logic             done,
   input  logic             err_in,
   output logic             busy,
   output logic             fail,
   output logic             pend,
   output logic [CMD_W-1:0] cmd,
   output logic             start,
   output logic             finish
);
   logic accept;

   assign accept = cmd_wr && !busy;
   assign finish = done && busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         fail  <= 1'b0;
         cmd   <= '0;
         start <= 1'b0;
      end else begin
         start <= accept;
         if (accept) begin
            busy <= 1'b1;
            fail <= 1'b0;
            cmd  <= cmd_in;
         end else if (finish) begin
            busy <= 1'b0;
            fail <= err_in;
         end
      end
   end

   generate
      if (IRQ_EN) begin : g_irq
         always_ff @(posedge clk) begin
            if (!rst_n)      pend <= 1'b0;
            else if (finish) pend <= 1'b1;
            else if (ver_wr) pend <= 1'b0;
         end
         // R10
         irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            finish |=> pend);
      end else begin : g_no_irq
         assign pend = 1'b0;
      end
   endgenerate

   // R3
   busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !busy) |=> (busy && start));
   // R3
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);
   // R4
   no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && busy) |=> (!start && $stable(cmd)));
   // R7
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && busy) |=> !busy);
endmodule

// File: rtl/mbx_words.sv
module mbx_words #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr0,
   input  logic              wr1,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy,
   input  logic              finish,
   input  logic [DATA_W-1:0] res0,
   input  logic [DATA_W-1:0] res1,
   output logic [DATA_W-1:0] word0,
   output logic [DATA_W-1:0] word1
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word0 <= '0;
         word1 <= '0;
      end else if (finish) begin
         word0 <= res0;
         word1 <= res1;
      end else if (!busy) begin
         if (wr0) word0 <= wdata;
         if (wr1) word1 <= wdata;
      end
   end

   // R6
   args_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !finish) |=> ($stable(word0) && $stable(word1)));
   // R7
   result_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> (word0 == $past(res0) && word1 == $past(res1)));
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox #(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       DATA_W     = 32,
   parameter int unsigned       CMD_W      = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR  = 32'h1FFF_0000,
   parameter logic [DATA_W-1:0] HW_VERSION = 32'h4D42_0001,
   parameter bit                IRQ_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              ctl_start,
   output logic [CMD_W-1:0]  ctl_cmd,
   output logic [DATA_W-1:0] ctl_arg0,
   output logic [DATA_W-1:0] ctl_arg1,
   input  logic              ctl_done,
   input  logic              ctl_error,
   input  logic [DATA_W-1:0] ctl_res0,
   input  logic [DATA_W-1:0] ctl_res1,
   output logic              irq
);
   import mbx_pkg::*;

   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("cmd_mailbox: status layout needs DATA_W == 32");
      end
      if (CMD_W < 1 || CMD_W > 8) begin : g_bad_cmd
         $error("cmd_mailbox: CMD_W must be 1..8");
      end
   endgenerate

   logic     hit, wr_stat, wr_wd0, wr_wd1, wr_ver;
   logic     busy, fail, pend, finish;
   mbx_sel_t sel;

   mbx_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
      .addr(host_addr), .wr(host_wr), .hit(hit), .sel(sel),
      .wr_stat(wr_stat), .wr_wd0(wr_wd0), .wr_wd1(wr_wd1), .wr_ver(wr_ver)
   );

   mbx_ctrl #(.CMD_W(CMD_W), .IRQ_EN(IRQ_EN)) u_ctl (
      .clk(clk), .rst_n(rst_n), .cmd_wr(wr_stat), .ver_wr(wr_ver),
      .cmd_in(host_wdata[CMD_W-1:0]), .done(ctl_done), .err_in(ctl_error),
      .busy(busy), .fail(fail), .pend(pend), .cmd(ctl_cmd),
      .start(ctl_start), .finish(finish)
   );

   mbx_words #(.DATA_W(DATA_W)) u_wds (
      .clk(clk), .rst_n(rst_n), .wr0(wr_wd0), .wr1(wr_wd1),
      .wdata(host_wdata), .busy(busy), .finish(finish),
      .res0(ctl_res0), .res1(ctl_res1), .word0(ctl_arg0), .word1(ctl_arg1)
   );

   assign irq = pend;

   always_comb begin
      host_rdata = '0;
      if (hit) begin
         unique case (sel)
            SEL_STAT: begin
               host_rdata[BUSY_POS]  = busy;
               host_rdata[FAIL_POS]  = fail;
               host_rdata[PEND_POS]  = pend;
               host_rdata[CMD_W-1:0] = ctl_cmd;
            end
            SEL_WD0: host_rdata = ctl_arg0;
            SEL_WD1: host_rdata = ctl_arg1;
            SEL_VER: host_rdata = HW_VERSION;
            default: host_rdata = '0;
         endcase
      end
   end

   // R9
   idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_done && !busy && !wr_stat && !wr_wd0 && !wr_wd1) |=>
         ($stable(ctl_arg0) && $stable(ctl_arg1) && !busy));
   // R8
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !busy) |=> !fail);
endmodule

// File: tb/sim_cmd_mailbox.sv
module sim_cmd_mailbox;
   localparam int CLK_NS = 10;
   localparam logic [31:0] BASE = 32'h1FFF_0000;
   localparam logic [31:0] VER  = 32'h4D42_0001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [31:0] host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        ctl_start;
   logic [7:0]  ctl_cmd;
   logic [31:0] ctl_arg0, ctl_arg1;
   logic        ctl_done = 1'b0;
   logic        ctl_error = 1'b0;
   logic [31:0] ctl_res0 = '0;
   logic [31:0] ctl_res1 = '0;
   logic        irq;

   int   n_run = 0;
   int   n_fail = 0;
   bit   finished = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_NS/2) clk = ~clk;

   cmd_mailbox u0 (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .ctl_start(ctl_start), .ctl_cmd(ctl_cmd), .ctl_arg0(ctl_arg0),
      .ctl_arg1(ctl_arg1), .ctl_done(ctl_done), .ctl_error(ctl_error),
      .ctl_res0(ctl_res0), .ctl_res1(ctl_res1), .irq(irq)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp,
                        input string tag);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: compares queued read expectations at the falling edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         check(host_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
   end

   // driver: place an address and queue the expected read value
   task automatic expect_rd(input logic [31:0] addr, input logic [31:0] exp,
                            input string tag);
      @(posedge clk); #1;
      host_addr = addr;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk); #1;
   endtask

   task automatic wr(input logic [31:0] addr, input logic [31:0] data);
      @(posedge clk); #1;
      host_wr = 1'b1; host_addr = addr; host_wdata = data;
      @(posedge clk); #1;
      host_wr = 1'b0;
   endtask

   task automatic finish_op(input logic err, input logic [31:0] r0,
                            input logic [31:0] r1);
      @(posedge clk); #1;
      ctl_done = 1'b1; ctl_error = err; ctl_res0 = r0; ctl_res1 = r1;
      @(posedge clk); #1;
      ctl_done = 1'b0; ctl_error = 1'b0;
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      expect_rd(BASE + 0, 32'h0, "R1 status");
      expect_rd(BASE + 4, 32'h0, "R1 word0");
      check({31'b0, irq}, 32'h0, "R1 irq");
      check({31'b0, ctl_start}, 32'h0, "R1 start");
      // R11 version constant, write has no effect on it
      expect_rd(BASE + 12, VER, "R11 version");
      wr(BASE + 12, 32'h0);
      expect_rd(BASE + 12, VER, "R11 version after write");
      // R5 argument words
      wr(BASE + 4, 32'hA5A5_5A5A);
      wr(BASE + 8, 32'h0000_1234);
      expect_rd(BASE + 4, 32'hA5A5_5A5A, "R5 word0");
      expect_rd(BASE + 8, 32'h0000_1234, "R5 word1");
      check(ctl_arg0, 32'hA5A5_5A5A, "R5 ctl_arg0");
      check(ctl_arg1, 32'h0000_1234, "R5 ctl_arg1");
      // R3 command accept
      wr(BASE + 0, 32'h0000_1342);
      check({31'b0, ctl_start}, 32'h1, "R3 start high");
      check({24'b0, ctl_cmd}, 32'h42, "R3 ctl_cmd");
      @(posedge clk); #1;
      check({31'b0, ctl_start}, 32'h0, "R3 start one cycle");
      // R2 layout: busy bit 31, cmd 7:0
      expect_rd(BASE + 0, 32'h8000_0042, "R2 status busy");
      // R4 command while busy ignored
      wr(BASE + 0, 32'h0000_0077);
      check({31'b0, ctl_start}, 32'h0, "R4 no start");
      expect_rd(BASE + 0, 32'h8000_0042, "R4 status kept");
      // R6 data writes while busy ignored
      wr(BASE + 4, 32'h0000_DEAD);
      wr(BASE + 8, 32'h0000_BEEF);
      expect_rd(BASE + 4, 32'hA5A5_5A5A, "R6 word0 kept");
      expect_rd(BASE + 8, 32'h0000_1234, "R6 word1 kept");
      // R7 successful completion, R10 interrupt
      finish_op(1'b0, 32'h1111_1111, 32'h2222_2222);
      expect_rd(BASE + 0, 32'h2000_0042, "R7 status done");
      expect_rd(BASE + 4, 32'h1111_1111, "R7 result0");
      expect_rd(BASE + 8, 32'h2222_2222, "R7 result1");
      check({31'b0, irq}, 32'h1, "R10 irq raised");
      wr(BASE + 12, 32'h0);
      check({31'b0, irq}, 32'h0, "R10 irq cleared");
      expect_rd(BASE + 0, 32'h0000_0042, "R10 pending cleared");
      // R9 done while idle ignored
      finish_op(1'b1, 32'h9999_9999, 32'h8888_8888);
      expect_rd(BASE + 0, 32'h0000_0042, "R9 status kept");
      expect_rd(BASE + 4, 32'h1111_1111, "R9 word0 kept");
      check({31'b0, irq}, 32'h0, "R9 no irq");
      // R7 failed completion: error code in word0
      wr(BASE + 0, 32'h0000_0005);
      finish_op(1'b1, 32'hE0E0_0007, 32'h0);
      expect_rd(BASE + 0, 32'h6000_0005, "R7 status error");
      expect_rd(BASE + 4, 32'hE0E0_0007, "R7 error code");
      // R8 new command clears error
      wr(BASE + 12, 32'h0);
      wr(BASE + 0, 32'h0000_0006);
      expect_rd(BASE + 0, 32'h8000_0006, "R8 error cleared");
      // R10 completion and clear on the same edge: set wins
      @(posedge clk); #1;
      ctl_done = 1'b1; ctl_res0 = 32'h0; ctl_res1 = 32'h0;
      host_wr = 1'b1; host_addr = BASE + 12; host_wdata = 32'h0;
      @(posedge clk); #1;
      ctl_done = 1'b0; host_wr = 1'b0;
      check({31'b0, irq}, 32'h1, "R10 set wins");
      expect_rd(BASE + 0, 32'h2000_0006, "R10 status set wins");
      // R12 outside the window
      wr(BASE + 16, 32'h0000_0055);
      wr(32'h0000_0000, 32'h0000_0033);
      check({31'b0, ctl_start}, 32'h0, "R12 no start");
      expect_rd(BASE + 16, 32'h0, "R12 read beyond");
      expect_rd(32'h0000_0004, 32'h0, "R12 read below");
      expect_rd(BASE + 0, 32'h2000_0006, "R12 status untouched");
      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule